// File: doc/BRIEF.md
# Selectable Unsigned Magnitude Comparator

This block compares two unsigned operands of the same parameterised width. A 3-bit operation code chooses one of six relations, and the block returns a one-bit verdict. The operand `b` is always the subject of the relation, so "greater" asks whether `b` exceeds `a`, and "less-or-equal" asks whether `b` is at most `a`.

Equality and inequality come from a per-bit difference vector. Each bit of that vector is `a[i] XOR b[i]`, and a ripple OR reduces the vector. The two ordering relations come from a sum-of-products chain that runs from the most significant bit downward. Each product term needs one operand bit set where the other is clear, and it also needs every higher bit pair to match. For the inclusive relations, an all-bits-equal product is ORed in. No subtractor is used. There is no state machine, because the logic is purely combinational. One output register follows the comparison so that the result is presented on a clock edge.

Top module: `sel_mag_cmp`

## Requirements
- R1: With code 3'b000 the result is 1 exactly when `b_i == a_i`.
- R2: With code 3'b001 the result is 1 exactly when `b_i != a_i`.
- R3: With code 3'b010 the result is 1 exactly when `b_i > a_i`, and both operands are treated as unsigned.
- R4: With code 3'b011 the result is 1 exactly when `b_i >= a_i`, unsigned.
- R5: With code 3'b100 the result is 1 exactly when `b_i < a_i`, unsigned.
- R6: With code 3'b101 the result is 1 exactly when `b_i <= a_i`, unsigned.
- R7: Codes 3'b110 and 3'b111 give a result of 0 for every pair of operands.
- R8: The result for the operands and code sampled at one rising clock edge appears on `res_o` after that edge. While `rst_n` is low, `res_o` is 0.
- R9: The relations hold at every width from 1 to 32, including the extreme values 0 and all-ones, and including operands that differ only in the most significant bit.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset of the result register |
| a_i | input | WIDTH | Reference operand, unsigned |
| b_i | input | WIDTH | Subject operand, unsigned |
| op_i | input | 3 | Relation select code |
| res_o | output | 1 | Registered verdict |

## Verification
Every verdict is due exactly one rising edge after its operands and code are presented. This latency comes from the single output register, because the comparison logic itself is combinational. The bench changes its inputs on a falling edge and reads `res_o` on the next falling edge. At that point the value has been captured by exactly one rising edge, and the inputs for the following check have not yet been captured. The checker's properties use the same one-cycle offset: they compare `res_o` against the relation of the inputs sampled one edge earlier.

// File: rtl/smc_pkg.sv
package smc_pkg;

    typedef enum logic [2:0] {
        OP_EQ  = 3'b000,
        OP_NE  = 3'b001,
        OP_GT  = 3'b010,
        OP_GE  = 3'b011,
        OP_LT  = 3'b100,
        OP_LE  = 3'b101,
        OP_RSV0 = 3'b110,
        OP_RSV1 = 3'b111
    } op_e;

    localparam int unsigned MIN_WIDTH = 1;
    localparam int unsigned MAX_WIDTH = 32;

endpackage

// File: rtl/smc_bit_eq.sv
// Per-bit difference vector, its ripple OR reduction and the
// per-bit match terms consumed by the ordering chains.
module smc_bit_eq #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    output logic [WIDTH-1:0] match_o,
    output logic             any_diff_o
);

    logic [WIDTH-1:0] diff;
    logic [WIDTH-1:0] or_rip;

    always_comb begin
        diff    = a_i ^ b_i;
        match_o = ~diff;
        or_rip[0] = diff[0];
        for (int i = 1; i < WIDTH; i++) begin
            or_rip[i] = or_rip[i-1] | diff[i];
        end
        any_diff_o = or_rip[WIDTH-1];
    end

endmodule

// File: rtl/smc_order_chain.sv
// Strict "hi above lo" built as a sum of products: a bit where hi is
// set and lo is clear, qualified by all higher bits matching.
// The full match product is returned for the inclusive relations.
module smc_order_chain #(
    parameter int unsigned WIDTH = 8
) (
    input  logic [WIDTH-1:0] hi_i,
    input  logic [WIDTH-1:0] lo_i,
    input  logic [WIDTH-1:0] match_i,
    output logic             above_o,
    output logic             all_match_o
);

    logic [WIDTH:0]   prefix;
    logic [WIDTH-1:0] prod;
    logic [WIDTH:0]   acc;

    always_comb begin
        prefix[WIDTH] = 1'b1;
        acc[WIDTH]    = 1'b0;
        for (int i = WIDTH - 1; i >= 0; i--) begin
            prod[i]   = hi_i[i] & ~lo_i[i] & prefix[i+1];
            prefix[i] = prefix[i+1] & match_i[i];
            acc[i]    = acc[i+1] | prod[i];
        end
        above_o     = acc[0];
        all_match_o = prefix[0];
    end

endmodule

// File: rtl/smc_rel_mux.sv
// Chooses one relation from the code; reserved codes give 0.
module smc_rel_mux
    import smc_pkg::*;
(
    input  logic [2:0] op_i,
    input  logic       eq_i,
    input  logic       ne_i,
    input  logic       b_gt_i,
    input  logic       b_ge_i,
    input  logic       b_lt_i,
    input  logic       b_le_i,
    output logic       sel_o
);

    op_e op;

    always_comb begin
        op = op_e'(op_i);
        unique case (op)
            OP_EQ:   sel_o = eq_i;
            OP_NE:   sel_o = ne_i;
            OP_GT:   sel_o = b_gt_i;
            OP_GE:   sel_o = b_ge_i;
            OP_LT:   sel_o = b_lt_i;
            OP_LE:   sel_o = b_le_i;
            default: sel_o = 1'b0;
        endcase
    end

endmodule

// File: rtl/sel_mag_cmp.sv
module sel_mag_cmp
    import smc_pkg::*;
#(
    parameter int unsigned WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [WIDTH-1:0] a_i,
    input  logic [WIDTH-1:0] b_i,
    input  logic [2:0]       op_i,
    output logic             res_o
);

    logic [WIDTH-1:0] match;
    logic             any_diff;
    logic             a_above_b;
    logic             b_above_a;
    logic             all_eq_ab;
    logic             all_eq_ba;
    logic             rel_eq;
    logic             rel_ne;
    logic             rel_gt;
    logic             rel_ge;
    logic             rel_lt;
    logic             rel_le;
    logic             verdict;
    logic             res_q;

    smc_bit_eq #(.WIDTH(WIDTH)) u_bit_eq (
        .a_i        (a_i),
        .b_i        (b_i),
        .match_o    (match),
        .any_diff_o (any_diff)
    );

    // b below a  (b < a, and b <= a with the full match term)
    smc_order_chain #(.WIDTH(WIDTH)) u_chain_ab (
        .hi_i        (a_i),
        .lo_i        (b_i),
        .match_i     (match),
        .above_o     (a_above_b),
        .all_match_o (all_eq_ab)
    );

    // b above a  (b > a, and b >= a with the full match term)
    smc_order_chain #(.WIDTH(WIDTH)) u_chain_ba (
        .hi_i        (b_i),
        .lo_i        (a_i),
        .match_i     (match),
        .above_o     (b_above_a),
        .all_match_o (all_eq_ba)
    );

    always_comb begin
        rel_ne = any_diff;
        rel_eq = ~any_diff;
        rel_gt = b_above_a;
        rel_ge = b_above_a | all_eq_ba;
        rel_lt = a_above_b;
        rel_le = a_above_b | all_eq_ab;
    end

    smc_rel_mux u_mux (
        .op_i   (op_i),
        .eq_i   (rel_eq),
        .ne_i   (rel_ne),
        .b_gt_i (rel_gt),
        .b_ge_i (rel_ge),
        .b_lt_i (rel_lt),
        .b_le_i (rel_le),
        .sel_o  (verdict)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            res_q <= 1'b0;
        end else begin
            res_q <= verdict;
        end
    end

    assign res_o = res_q;

endmodule

// File: rtl/sel_mag_cmp_chk.sv
module sel_mag_cmp_chk #(
    parameter int unsigned WIDTH = 8
) (
    input logic             clk,
    input logic             rst_n,
    input logic [WIDTH-1:0] a_i,
    input logic [WIDTH-1:0] b_i,
    input logic [2:0]       op_i,
    input logic             res_o
);

    assert_eq_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b000) |=> (res_o == $past(b_i == a_i)));

    assert_ne_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b001) |=> (res_o == $past(b_i != a_i)));

    assert_gt_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b010) |=> (res_o == $past(b_i > a_i)));

    assert_ge_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b011) |=> (res_o == $past(b_i >= a_i)));

    assert_lt_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b100) |=> (res_o == $past(b_i < a_i)));

    assert_le_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i == 3'b101) |=> (res_o == $past(b_i <= a_i)));

    assert_reserved_zero_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (op_i[2:1] == 2'b11) |=> !res_o);

endmodule

bind sel_mag_cmp sel_mag_cmp_chk #(.WIDTH(WIDTH)) u_chk (
    .clk   (clk),
    .rst_n (rst_n),
    .a_i   (a_i),
    .b_i   (b_i),
    .op_i  (op_i),
    .res_o (res_o)
);

// File: tb/sel_mag_cmp_tb.sv
module sel_mag_cmp_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [2:0]  op = 3'b000;
    logic [3:0]  a4 = '0, b4 = '0;
    logic [15:0] a16 = '0, b16 = '0;
    logic        a1 = 1'b0, b1 = 1'b0;
    logic        res4, res16, res1;

    int n_cmp  = 0;
    int n_fail = 0;
    bit done   = 1'b0;

    always #4 clk = ~clk;  // 125 MHz

    sel_mag_cmp #(.WIDTH(4))  u_dut   (.clk(clk), .rst_n(rst_n), .a_i(a4),  .b_i(b4),  .op_i(op), .res_o(res4));
    sel_mag_cmp #(.WIDTH(16)) u_dut16 (.clk(clk), .rst_n(rst_n), .a_i(a16), .b_i(b16), .op_i(op), .res_o(res16));
    sel_mag_cmp #(.WIDTH(1))  u_dut1  (.clk(clk), .rst_n(rst_n), .a_i(a1),  .b_i(b1),  .op_i(op), .res_o(res1));

    function automatic bit ref_rel(input logic [2:0] o, input logic [31:0] a, input logic [31:0] b);
        case (o)
            3'b000:  return b == a;
            3'b001:  return b != a;
            3'b010:  return b > a;
            3'b011:  return b >= a;
            3'b100:  return b < a;
            3'b101:  return b <= a;
            default: return 1'b0;
        endcase
    endfunction

    function automatic string req_of(input logic [2:0] o);
        case (o)
            3'b000:  return "R1";
            3'b001:  return "R2";
            3'b010:  return "R3";
            3'b011:  return "R4";
            3'b100:  return "R5";
            3'b101:  return "R6";
            default: return "R7";
        endcase
    endfunction

    task automatic check(input string req, input string what, input logic got, input logic exp);
        n_cmp++;
        if (got !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual=%b expected=%b", req, what, got, exp);
        end
    endtask

    // inputs were driven at the previous falling edge; one rising edge
    // has captured them; sample here on the falling edge
    task automatic settle_and_check(input bit chk4, input bit chk16, input bit chk1);
        logic [2:0]  so   = op;
        logic [3:0]  sa4  = a4,  sb4  = b4;
        logic [15:0] sa16 = a16, sb16 = b16;
        logic        sa1  = a1,  sb1  = b1;
        @(negedge clk);
        if (chk4)  check(req_of(so), $sformatf("w4 op=%0d a=%h b=%h", so, sa4, sb4),
                         res4, ref_rel(so, 32'(sa4), 32'(sb4)));
        if (chk16) check(req_of(so), $sformatf("R9 w16 op=%0d a=%h b=%h", so, sa16, sb16),
                         res16, ref_rel(so, 32'(sa16), 32'(sb16)));
        if (chk1)  check(req_of(so), $sformatf("R9 w1 op=%0d a=%b b=%b", so, sa1, sb1),
                         res1, ref_rel(so, 32'(sa1), 32'(sb1)));
    endtask

    task automatic rand16();
        a16 = 16'($urandom);
        b16 = (($urandom % 4) == 0) ? a16 : 16'($urandom);
    endtask

    initial begin
        void'($urandom(32'd31337));
        // reset: inputs chosen so a live register would show 1
        op = 3'b000; a4 = 4'h5; b4 = 4'h5; a16 = 16'h1234; b16 = 16'h1234;
        repeat (3) @(negedge clk);
        check("R8", "reset w4",  res4,  1'b0);
        check("R8", "reset w16", res16, 1'b0);
        check("R8", "reset w1",  res1,  1'b0);
        rst_n = 1'b1;

        // one-edge latency: result of this set visible next falling edge
        op = 3'b000; a4 = 4'h9; b4 = 4'h9;
        settle_and_check(1'b1, 1'b0, 1'b0);
        check("R8", "latency eq w4", res4, 1'b1);

        // exhaustive width 4 and width 1, random width 16, every code
        for (int o = 0; o < 8; o++) begin
            for (int a = 0; a < 16; a++) begin
                for (int b = 0; b < 16; b++) begin
                    op = 3'(o);
                    a4 = 4'(a); b4 = 4'(b);
                    a1 = a[0];  b1 = b[0];
                    rand16();
                    settle_and_check(1'b1, 1'b1, 1'b1);
                end
            end
        end

        // width 16 directed corners for R9 (unsigned, MSB-only difference)
        for (int o = 0; o < 8; o++) begin
            for (int k = 0; k < 7; k++) begin
                op = 3'(o);
                case (k)
                    0: begin a16 = 16'h0000; b16 = 16'h0000; end
                    1: begin a16 = 16'hFFFF; b16 = 16'hFFFF; end
                    2: begin a16 = 16'h8000; b16 = 16'h7FFF; end
                    3: begin a16 = 16'h7FFF; b16 = 16'h8000; end
                    4: begin a16 = 16'h0000; b16 = 16'hFFFF; end
                    5: begin a16 = 16'h8001; b16 = 16'h0001; end
                    default: begin a16 = 16'h1230; b16 = 16'h1231; end
                endcase
                settle_and_check(1'b0, 1'b1, 1'b0);
            end
        end

        // width 16 random, all codes
        for (int n = 0; n < 2000; n++) begin
            op = 3'($urandom % 8);
            rand16();
            settle_and_check(1'b0, 1'b1, 1'b0);
        end

        // reset reasserted mid-run clears the result (R8)
        op = 3'b000; a4 = 4'h3; b4 = 4'h3;
        @(negedge clk);
        check("R8", "eq before reset", res4, 1'b1);
        rst_n = 1'b0;
        #1;
        check("R8", "async clear", res4, 1'b0);
        @(negedge clk);
        check("R8", "held in reset", res4, 1'b0);

        if (!done) begin
            done = 1'b1;
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1'b1;
            n_cmp++;
            n_fail++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_fail);
            $finish;
        end
    end

endmodule